// File: doc/BRIEF.md
# Port-Linked ROM Bank Switch Controller

This block sits beside the instruction fetch path of a calculator-style processor whose ROM space is divided into sixteen 4K-word pages. It watches every fetched 10-bit instruction word. When a bank-enable opcode executes from a switchable page, the block records the requested bank for that page's switching group. The ROM address mapper reads the current bank of every page from a flat output vector.

Pages are grouped by how they switch. Each even/odd pair in the upper half of the space (8/9, A/B, C/D, E/F) shares one bank register. Pages 4, 6 and 7 each have a register of their own. Pages 3 and 5 share a register, so code in page 3 can select a bank and then jump into page 5. The operating-system pages 0, 1 and 2 never switch.

A per-page enable mask lets the integrator block switching from pages that hold RAM instead of ROM. A new bank applies from the fetch after the one that carried the opcode.

Top module: `rom_bank_ctrl`

## Requirements
- R1: A bank-enable opcode selects a bank by its value: 0x100 selects bank 1, 0x180 bank 2, 0x140 bank 3 and 0x1C0 bank 4. The bank of page p appears on `pageBank[2p+1:2p]` as the bank number minus one (code 0 to 3).
- R2: A bank-enable opcode fetched from either page of the pairs 8/9, A/B, C/D or E/F changes the bank of both pages of that pair.
- R3: A bank-enable opcode fetched from page 4, 6 or 7 changes only the bank of that page.
- R4: Pages 3 and 5 share one bank. An opcode fetched from either of them changes both.
- R5: Pages 0, 1 and 2 always show code 0. A bank-enable opcode fetched from them changes no bank.
- R6: A bank change leaves the bank of every other group unchanged.
- R7: After reset, every page shows code 0 (bank 1).
- R8: The new bank appears on the outputs after the clock edge that captures the opcode fetch, not during that fetch cycle.
- R9: When `switchEn[p]` is 0 for the fetching page p, an opcode from that page changes no bank.
- R10: A fetch changes no bank when `fetchValid` is 0. It also changes no bank when the word is not a bank-enable opcode. A word is a bank-enable opcode only when bit 9 is 0, bit 8 is 1 and bits 5:0 are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| fetchValid | input | 1 | High in a cycle that carries an executed fetch |
| fetchPage | input | 4 | Page number of the fetched word |
| fetchWord | input | 10 | Fetched instruction word |
| switchEn | input | 16 | Per-page switching enable, one bit per page |
| pageBank | output | 32 | Bank code of each page, two bits per page |

## Verification
The main function is driven with opcodes from each kind of group:
- A linked pair, hit from either page.
- The 3/5 link, hit from both ends.
- The standalone pages.
- The operating-system pages.

Each fetch is followed by probes of the issuing page, its partner and an unrelated page. These probes separate a register shared too widely from one not shared at all.

Near-miss words show whether the opcode decode is loose. These are a bank opcode with a low bit set and a bank opcode with bit 9 set. Invalid fetches and masked pages are also tried.

A probe inside the fetch cycle confirms that a wrong register stage would show the new bank too early.

// File: rtl/rbk_pkg.sv
package rbk_pkg;
  localparam int NUM_PAGES = 16;
  localparam int PAGE_W    = $clog2(NUM_PAGES);
  localparam int OP_W      = 10;
  localparam int BANK_W    = 2;
  localparam int NUM_GRPS  = 8;
  localparam int GRP_W     = $clog2(NUM_GRPS);

  typedef struct packed {
    logic [NUM_GRPS-1:0] grpWr;
    logic [BANK_W-1:0]   newBank;
  } bankCtl_t;

  // Returns {switchable, group index}; OS pages return switchable = 0.
  function automatic logic [GRP_W:0] groupOf(input logic [PAGE_W-1:0] page);
    logic [GRP_W:0] g;
    case (page)
      4'h3, 4'h5: g = {1'b1, 3'd0};
      4'h4:       g = {1'b1, 3'd1};
      4'h6:       g = {1'b1, 3'd2};
      4'h7:       g = {1'b1, 3'd3};
      4'h8, 4'h9: g = {1'b1, 3'd4};
      4'hA, 4'hB: g = {1'b1, 3'd5};
      4'hC, 4'hD: g = {1'b1, 3'd6};
      4'hE, 4'hF: g = {1'b1, 3'd7};
      default:    g = '0;
    endcase
    return g;
  endfunction
endpackage

// File: rtl/rbk_ctrl.sv
module rbk_ctrl
  import rbk_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              fetchValid,
  input  logic [PAGE_W-1:0] fetchPage,
  input  logic [OP_W-1:0]   fetchWord,
  input  logic [NUM_PAGES-1:0] switchEn,
  output bankCtl_t          ctl
);
  logic isBankOp;
  logic [GRP_W:0] grpSel;

  always_comb begin
    isBankOp = !fetchWord[9] && fetchWord[8] && (fetchWord[5:0] == '0);
    grpSel   = groupOf(fetchPage);
    ctl      = '0;
    // bit 7 adds one, bit 6 adds two: 0x100->0, 0x180->1, 0x140->2, 0x1C0->3
    ctl.newBank = {fetchWord[6], fetchWord[7]};
    if (fetchValid && isBankOp && switchEn[fetchPage] && grpSel[GRP_W])
      ctl.grpWr[grpSel[GRP_W-1:0]] = 1'b1;
  end

  assert_valid_gate_R10: assert property (@(posedge clk) disable iff (!rstN)
    !fetchValid |-> ctl.grpWr == '0);
  assert_mask_gate_R9: assert property (@(posedge clk) disable iff (!rstN)
    !switchEn[fetchPage] |-> ctl.grpWr == '0);
  assert_single_group_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ctl.grpWr));
endmodule

// File: rtl/rbk_regs.sv
module rbk_regs
  import rbk_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  bankCtl_t ctl,
  output logic [NUM_PAGES*BANK_W-1:0] pageBank
);
  logic [BANK_W-1:0] grpBank [NUM_GRPS];

  for (genvar g = 0; g < NUM_GRPS; g++) begin : gGrp
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              grpBank[g] <= '0;
      else if (ctl.grpWr[g])  grpBank[g] <= ctl.newBank;
    end

    assert_load_R1: assert property (@(posedge clk) disable iff (!rstN)
      ctl.grpWr[g] |=> grpBank[g] == $past(ctl.newBank));
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
      !ctl.grpWr[g] |=> $stable(grpBank[g]));
  end

  for (genvar p = 0; p < NUM_PAGES; p++) begin : gPage
    localparam logic [GRP_W:0] PG = groupOf(PAGE_W'(p));
    if (PG[GRP_W]) begin : gSw
      assign pageBank[p*BANK_W +: BANK_W] = grpBank[PG[GRP_W-1:0]];
    end else begin : gFixed
      assign pageBank[p*BANK_W +: BANK_W] = '0;
    end
  end
endmodule

// File: rtl/rom_bank_ctrl.sv
module rom_bank_ctrl
  import rbk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        fetchValid,
  input  logic [3:0]  fetchPage,
  input  logic [9:0]  fetchWord,
  input  logic [15:0] switchEn,
  output logic [31:0] pageBank
);
  bankCtl_t ctl;

  rbk_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .fetchPage(fetchPage),
    .fetchWord(fetchWord), .switchEn(switchEn), .ctl(ctl)
  );

  rbk_regs u_regs (
    .clk(clk), .rstN(rstN), .ctl(ctl), .pageBank(pageBank)
  );
endmodule

// File: tb/rom_bank_ctrl_tb.sv
module rom_bank_ctrl_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fetchValid = 1'b0;
  logic [3:0]  fetchPage = '0;
  logic [9:0]  fetchWord = '0;
  logic [15:0] switchEn = '1;
  logic [31:0] pageBank;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  rom_bank_ctrl u_dut (
    .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .fetchPage(fetchPage),
    .fetchWord(fetchWord), .switchEn(switchEn), .pageBank(pageBank)
  );

  typedef struct packed {
    logic       v;
    logic [3:0] pg;
    logic [9:0] op;
    logic [3:0] pa;
    logic [1:0] ea;
    logic [3:0] pb;
    logic [1:0] eb;
  } vec_t;

  localparam vec_t VECS [14] = '{
    '{1'b1, 4'h8, 10'h180, 4'h8, 2'd1, 4'h9, 2'd1},  // R2 pair from even page
    '{1'b1, 4'hF, 10'h1C0, 4'hE, 2'd3, 4'hF, 2'd3},  // R2 pair from odd page
    '{1'b1, 4'h3, 10'h140, 4'h3, 2'd2, 4'h5, 2'd2},  // R4 from page 3
    '{1'b1, 4'h5, 10'h180, 4'h3, 2'd1, 4'h5, 2'd1},  // R4 from page 5
    '{1'b1, 4'h4, 10'h1C0, 4'h4, 2'd3, 4'h6, 2'd0},  // R3 page 4 alone
    '{1'b1, 4'h7, 10'h140, 4'h7, 2'd2, 4'h6, 2'd0},  // R3 page 7 alone
    '{1'b1, 4'h6, 10'h180, 4'h6, 2'd1, 4'h7, 2'd2},  // R3 page 6 alone
    '{1'b1, 4'h2, 10'h1C0, 4'h2, 2'd0, 4'h3, 2'd1},  // R5 OS page ignored
    '{1'b0, 4'hA, 10'h180, 4'hA, 2'd0, 4'hB, 2'd0},  // R10 strobe low
    '{1'b1, 4'hA, 10'h181, 4'hA, 2'd0, 4'h8, 2'd1},  // R10 near-miss opcode
    '{1'b1, 4'hB, 10'h140, 4'hA, 2'd2, 4'hB, 2'd2},  // R1 bank 3
    '{1'b1, 4'h9, 10'h100, 4'h8, 2'd0, 4'hE, 2'd3},  // R1 bank 1, R6 E kept
    '{1'b1, 4'h0, 10'h140, 4'h0, 2'd0, 4'h1, 2'd0},  // R5 page 0
    '{1'b1, 4'hC, 10'h3C0, 4'hC, 2'd0, 4'hD, 2'd0}   // R10 bit 9 set
  };

  // Expected code per page after the table (index = page)
  localparam logic [1:0] FINAL [16] = '{
    2'd0, 2'd0, 2'd0, 2'd1, 2'd3, 2'd1, 2'd1, 2'd2,
    2'd0, 2'd0, 2'd2, 2'd2, 2'd0, 2'd0, 2'd3, 2'd3
  };

  function automatic logic [1:0] bankOf(input int p);
    return pageBank[2*p +: 2];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doFetch(input logic v, input logic [3:0] pg, input logic [9:0] op);
    @(negedge clk);
    fetchValid = v; fetchPage = pg; fetchWord = op;
    @(negedge clk);
    fetchValid = 1'b0;
  endtask

  task automatic finish();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R7 reset", pageBank, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R7 after release", pageBank, 32'h0);

    for (int i = 0; i < 14; i++) begin
      doFetch(VECS[i].v, VECS[i].pg, VECS[i].op);
      check($sformatf("vec %0d probe A (R1-group)", i), 32'(bankOf(int'(VECS[i].pa))), 32'(VECS[i].ea));
      check($sformatf("vec %0d probe B (R6)", i), 32'(bankOf(int'(VECS[i].pb))), 32'(VECS[i].eb));
    end

    for (int p = 0; p < 16; p++)
      check($sformatf("R6 final page %0d", p), 32'(bankOf(p)), 32'(FINAL[p]));

    // R8: no change within the fetch cycle, change after the edge
    @(negedge clk);
    fetchValid = 1'b1; fetchPage = 4'h8; fetchWord = 10'h1C0;
    #1 check("R8 same cycle", 32'(bankOf(8)), 32'd0);
    @(negedge clk);
    fetchValid = 1'b0;
    check("R8 next cycle", 32'(bankOf(8)), 32'd3);
    check("R2 partner page 9", 32'(bankOf(9)), 32'd3);

    // R9: masked fetch page blocks switching of its group
    switchEn[13] = 1'b0;
    doFetch(1'b1, 4'hD, 10'h180);
    check("R9 masked page D", 32'(bankOf(13)), 32'd0);
    check("R9 masked partner C", 32'(bankOf(12)), 32'd0);
    doFetch(1'b1, 4'hC, 10'h180);
    check("R9 enabled page C", 32'(bankOf(12)), 32'd1);
    check("R9 partner D follows", 32'(bankOf(13)), 32'd1);
    switchEn = '1;

    // R5: pages 1 and 2 stay at code 0 after a direct attempt
    doFetch(1'b1, 4'h1, 10'h180);
    check("R5 page 1", 32'(bankOf(1)), 32'd0);

    // R7: reset mid-run clears all groups
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check("R7 mid-run reset", pageBank, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    finish();
  end
endmodule